// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of short outcome histories, one per entry, selected by low bits of the branch address. Each history keeps the last three resolved outcomes of the branches that map to that entry. In dynamic mode a lookup returns the majority of those three outcomes.

A mode bit comes with every lookup. The fetch logic takes it from the translation entry of the page that holds the branch. When the bit selects static mode, the table is not consulted. The prediction then comes from the branch direction: a backward branch is predicted taken and a forward branch untaken. An instruction hint bit can invert that rule.

Resolved outcomes arrive on a separate update port. They are shifted into the history whatever mode the page uses, so a page that moves to dynamic mode starts with a trained table. The history is kept in a block-RAM style array. A separate bank of per-entry flags, cleared by reset, marks which entries have been written since reset.

Top module: `branch_dir_predictor`

## Requirements
- R1: While reset is high and after it falls, every history reads as all-untaken, so a dynamic lookup of any entry predicts untaken. Both outputs are 0 while reset is high.
- R2: The table entry is chosen by address bits [9:2] (`lk_addr[9:2]`, `up_addr[9:2]`). All other address bits have no effect, so two addresses that agree in bits [9:2] share one entry.
- R3: In dynamic mode (`lk_static` = 0), `pred_taken` is 1 exactly when at least two of the three stored outcomes are taken.
- R4: Each update shifts `up_taken` (1 = taken) into the chosen history as the newest outcome, and the oldest of the three outcomes is dropped.
- R5: In static mode (`lk_static` = 1), `pred_taken` = `lk_backward` XOR `lk_hint`. `lk_backward` = 1 means a negative displacement (backward branch), and `lk_hint` = 1 inverts the rule. The history has no effect on a static lookup.
- R6: Updates to the same entry in consecutive cycles all accumulate, with none lost. Updates train the table whatever the mode of the lookups.
- R7: A lookup sampled on clock edge k gives its result on `pred_valid`/`pred_taken` just after edge k+1. An update sampled on edge j is seen by lookups sampled on edge j+2 or later. Lookups on edges j and j+1 see the earlier history.
- R8: `pred_valid` is 1 only for cycles that carry a lookup result. When `pred_valid` is 0, `pred_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present this cycle |
| lk_addr | input | ADDR_W (32) | Branch address of the lookup |
| lk_static | input | 1 | Page mode: 0 dynamic, 1 static |
| lk_backward | input | 1 | Displacement sign: 1 backward, 0 forward |
| lk_hint | input | 1 | Instruction predict bit, 1 inverts the static rule |
| up_valid | input | 1 | Resolved branch outcome present this cycle |
| up_addr | input | ADDR_W (32) | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 taken |
| pred_valid | output | 1 | Prediction result present |
| pred_taken | output | 1 | Predicted direction, 1 taken |

## Verification
A lookup's result is due one full cycle after it is sampled, on the second rising edge. An update reaches the table on the edge after it is sampled, so only lookups two or more edges later see it. The reference model mirrors this with a one-deep result pipe and a one-deep pending update. It applies the pending update only after it has computed the expected result of the current lookup. Outputs are sampled one time unit after each rising edge and compared on every clock, including idle cycles. Directed sequences place lookups on the same edge as an update and on the edge after it, and they send back-to-back updates to one entry.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int unsigned BDP_ADDR_W_DEF = 32;
  localparam int unsigned BDP_IDX_W_DEF  = 8;
  localparam int unsigned BDP_IDX_LSB_DEF = 2;
  localparam int unsigned BDP_HIST_W_DEF = 3;

  typedef enum logic {
    PM_DYNAMIC = 1'b0,
    PM_STATIC  = 1'b1
  } pred_mode_e;
endpackage

// File: rtl/bdp_hist_ram.sv
module bdp_hist_ram #(
  parameter int unsigned IDX_W  = bdp_pkg::BDP_IDX_W_DEF,
  parameter int unsigned HIST_W = bdp_pkg::BDP_HIST_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ra_en,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [HIST_W-1:0] ra_hist,
  input  logic              rb_en,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [HIST_W-1:0] rb_hist,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [HIST_W-1:0] w_hist
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [HIST_W-1:0] ra_q, rb_q;
  logic              ra_k, rb_k;

  // history array: no reset, read-old on collision
  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_hist;
    if (ra_en) ra_q <= mem[ra_idx];
    if (rb_en) rb_q <= mem[rb_idx];
  end

  // written-since-reset flags stand in for clearing the array
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else if (we) begin
      written[w_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_k <= 1'b0;
      rb_k <= 1'b0;
    end else begin
      if (ra_en) ra_k <= written[ra_idx];
      if (rb_en) rb_k <= written[rb_idx];
    end
  end

  assign ra_hist = ra_k ? ra_q : '0;
  assign rb_hist = rb_k ? rb_q : '0;

  // R7: a read issued the edge after a write returns the written history
  p_read_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && ra_en && (ra_idx == $past(w_idx))) |=> (ra_hist == $past(w_hist, 2)));
endmodule

// File: rtl/bdp_update.sv
module bdp_update #(
  parameter int unsigned IDX_W  = bdp_pkg::BDP_IDX_W_DEF,
  parameter int unsigned HIST_W = bdp_pkg::BDP_HIST_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic              up_taken,
  output logic              rb_en,
  output logic [IDX_W-1:0]  rb_idx,
  input  logic [HIST_W-1:0] rb_hist,
  output logic              we,
  output logic [IDX_W-1:0]  w_idx,
  output logic [HIST_W-1:0] w_hist
);
  logic              s_v;
  logic [IDX_W-1:0]  s_idx;
  logic              s_t;
  logic              s_fwd;
  logic [HIST_W-1:0] s_fwd_hist;
  logic [HIST_W-1:0] base;

  assign rb_en  = up_valid;
  assign rb_idx = up_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v   <= 1'b0;
      s_fwd <= 1'b0;
    end else begin
      s_v   <= up_valid;
      // the write on this edge is invisible to the read on this edge
      s_fwd <= we && (w_idx == up_idx);
    end
  end

  always_ff @(posedge clk) begin
    s_idx      <= up_idx;
    s_t        <= up_taken;
    s_fwd_hist <= w_hist;
  end

  always_comb begin
    base   = s_fwd ? s_fwd_hist : rb_hist;
    w_hist = {base[HIST_W-2:0], s_t};
  end

  assign we    = s_v;
  assign w_idx = s_idx;

  // R4: the newest outcome written is the one sampled on the previous edge
  p_newest_outcome_r4: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (we && (w_hist[0] == $past(up_taken))));
endmodule

// File: rtl/bdp_decide.sv
module bdp_decide #(
  parameter int unsigned HIST_W = bdp_pkg::BDP_HIST_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic              lk_static,
  input  logic              lk_backward,
  input  logic              lk_hint,
  input  logic [HIST_W-1:0] ra_hist,
  output logic              pred_valid,
  output logic              pred_taken
);
  import bdp_pkg::*;

  localparam int unsigned CW = $clog2(HIST_W + 1);

  logic              l_v;
  pred_mode_e        l_mode;
  logic              l_back;
  logic              l_hint;
  logic [CW-1:0]     votes;
  logic              maj;
  logic              next_dir;

  always_ff @(posedge clk) begin
    if (rst) l_v <= 1'b0;
    else     l_v <= lk_valid;
  end

  always_ff @(posedge clk) begin
    l_mode <= pred_mode_e'(lk_static);
    l_back <= lk_backward;
    l_hint <= lk_hint;
  end

  always_comb begin
    votes = '0;
    for (int i = 0; i < HIST_W; i++) votes = votes + CW'(ra_hist[i]);
    maj = (votes > CW'(HIST_W / 2));
    next_dir = (l_mode == PM_STATIC) ? (l_back ^ l_hint) : maj;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= l_v;
      pred_taken <= l_v && next_dir;
    end
  end

  // R7: result appears on the second edge after the lookup
  p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ##1 pred_valid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> ##1 !pred_valid);
  // R8: idle output is quiet
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> !pred_taken);
  // R5: static rule from the request fields alone
  p_static_rule_r5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_static) |=> ##1 (pred_taken == ($past(lk_backward, 2) ^ $past(lk_hint, 2))));
  // R3: dynamic result is the majority of the history read
  p_majority_r3: assert property (@(posedge clk) disable iff (rst)
    (l_v && (l_mode == PM_DYNAMIC)) |=> (pred_taken == ($countones($past(ra_hist)) > (HIST_W / 2))));
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
  parameter int unsigned ADDR_W  = bdp_pkg::BDP_ADDR_W_DEF,
  parameter int unsigned IDX_W   = bdp_pkg::BDP_IDX_W_DEF,
  parameter int unsigned IDX_LSB = bdp_pkg::BDP_IDX_LSB_DEF,
  parameter int unsigned HIST_W  = bdp_pkg::BDP_HIST_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_static,
  input  logic              lk_backward,
  input  logic              lk_hint,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  output logic              pred_valid,
  output logic              pred_taken
);
  localparam int unsigned IDX_HI = IDX_LSB + IDX_W;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] ra_hist, rb_hist, w_hist;
  logic              rb_en, we;
  logic [IDX_W-1:0]  rb_idx, w_idx;
  logic              unused_addr_bits;

  assign lk_idx = lk_addr[IDX_LSB +: IDX_W];
  assign up_idx = up_addr[IDX_LSB +: IDX_W];

  generate
    if (IDX_LSB > 0) begin : g_low
      assign unused_addr_bits = ^{lk_addr[ADDR_W-1:IDX_HI], lk_addr[IDX_LSB-1:0],
                                  up_addr[ADDR_W-1:IDX_HI], up_addr[IDX_LSB-1:0]};
    end else begin : g_nolow
      assign unused_addr_bits = ^{lk_addr[ADDR_W-1:IDX_HI], up_addr[ADDR_W-1:IDX_HI]};
    end
  endgenerate

  bdp_hist_ram #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_ram (
    .clk(clk), .rst(rst),
    .ra_en(lk_valid), .ra_idx(lk_idx), .ra_hist(ra_hist),
    .rb_en(rb_en), .rb_idx(rb_idx), .rb_hist(rb_hist),
    .we(we), .w_idx(w_idx), .w_hist(w_hist)
  );

  bdp_update #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_upd (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken),
    .rb_en(rb_en), .rb_idx(rb_idx), .rb_hist(rb_hist),
    .we(we), .w_idx(w_idx), .w_hist(w_hist)
  );

  bdp_decide #(.HIST_W(HIST_W)) u_dec (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_static(lk_static),
    .lk_backward(lk_backward), .lk_hint(lk_hint),
    .ra_hist(ra_hist),
    .pred_valid(pred_valid), .pred_taken(pred_taken)
  );
endmodule

// File: tb/branch_dir_predictor_test.sv
module branch_dir_predictor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_static = 1'b0;
  logic        lk_backward = 1'b0;
  logic        lk_hint = 1'b0;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;
  logic        pred_valid, pred_taken;

  int compared = 0;
  int mismatched = 0;

  int    mh [256];
  bit    pend_v = 0;
  int    pend_i = 0;
  bit    pend_t = 0;
  bit    exp_v_q = 0;
  bit    exp_t_q = 0;
  string prev_tag = "R8 idle output";

  branch_dir_predictor uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_static(lk_static),
    .lk_backward(lk_backward), .lk_hint(lk_hint),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int idx_of(input logic [31:0] a);
    return int'((a >> 2) & 32'hFF);
  endfunction

  function automatic int ones3(input int h);
    return (h & 1) + ((h >> 1) & 1) + ((h >> 2) & 1);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 256; i++) mh[i] = 0;
    pend_v = 0;
    exp_v_q = 0;
    exp_t_q = 0;
    prev_tag = "R8 idle output";
  endtask

  // R1: outputs quiet during reset, model cleared
  task automatic do_reset(input int n);
    rst = 1'b1;
    lk_valid = 1'b0;
    up_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check(pred_valid, 1'b0, "R1 pred_valid in reset");
      check(pred_taken, 1'b0, "R1 pred_taken in reset");
      @(negedge clk);
    end
    rst = 1'b0;
    model_clear();
  endtask

  task automatic step(input bit lv, input logic [31:0] la, input bit ls, input bit lb,
                      input bit lh, input bit uv, input logic [31:0] ua, input bit ut,
                      input string tag);
    bit ev;
    bit et;
    ev = lv;
    et = 1'b0;
    if (lv) begin
      if (ls) et = lb ^ lh;
      else    et = (ones3(mh[idx_of(la)]) >= 2);
    end
    if (pend_v) mh[pend_i] = ((mh[pend_i] << 1) | int'(pend_t)) & 7;
    pend_v = uv;
    pend_i = idx_of(ua);
    pend_t = ut;
    lk_valid = lv; lk_addr = la; lk_static = ls; lk_backward = lb; lk_hint = lh;
    up_valid = uv; up_addr = ua; up_taken = ut;
    @(posedge clk); #1;
    check(pred_valid, exp_v_q, exp_v_q ? {prev_tag, " (valid, R7)"} : "R8 idle valid");
    check(pred_taken, exp_v_q ? exp_t_q : 1'b0, exp_v_q ? prev_tag : "R8 idle taken");
    exp_v_q = ev;
    exp_t_q = et;
    prev_tag = tag;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, '0, 0, "R8 idle");
  endtask

  task automatic look(input logic [31:0] a, input bit ls, input bit lb, input bit lh,
                      input string tag);
    step(1, a, ls, lb, lh, 0, '0, 0, tag);
  endtask

  task automatic upd(input logic [31:0] a, input bit t, input string tag);
    step(0, '0, 0, 0, 0, 1, a, t, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] A;
    logic [31:0] B;
    A = 32'h0000_1040;
    B = 32'h0000_2084;
    @(negedge clk);
    do_reset(3);

    // R1: untouched entries predict untaken after reset
    look(32'h0, 0, 0, 0, "R1 entry 0 untaken");
    look(32'hFFFF_FFFC, 0, 0, 0, "R1 last entry untaken");
    look(A, 0, 0, 0, "R1 entry A untaken");
    idle(2);

    // R3/R4: shift history and majority at A
    upd(A, 1, "R4 train T");
    upd(A, 1, "R4 train T");
    idle(1);
    look(A, 0, 0, 0, "R3 two taken -> taken");
    upd(A, 0, "R4 shift N");
    idle(1);
    look(A, 0, 0, 0, "R3 TTN -> taken");
    upd(A, 0, "R4 shift N");
    idle(1);
    look(A, 0, 0, 0, "R4 TNN oldest dropped -> untaken");
    upd(A, 1, "R4 shift T");
    idle(1);
    look(A, 0, 0, 0, "R3 NNT -> untaken");
    upd(A, 1, "R4 shift T");
    idle(1);
    look(A, 0, 0, 0, "R3 NTT -> taken");
    upd(A, 1, "R4 shift T");
    idle(1);
    look(A, 0, 0, 0, "R3 TTT -> taken");

    // R6: back-to-back updates to one entry, lookups during the window (R7)
    upd(B, 1, "R6 burst 1");
    step(1, B, 0, 0, 0, 1, B, 1, "R7 lookup on update edge");
    look(B, 0, 0, 0, "R7 lookup edge after update");
    look(B, 0, 0, 0, "R6 burst accumulated");
    upd(B, 0, "R6 burst N");
    upd(B, 0, "R6 burst N");
    upd(B, 0, "R6 burst N");
    idle(1);
    look(B, 0, 0, 0, "R6 burst of three N -> untaken");

    // R5: static rule ignores history, all four combinations on a taken entry
    look(A, 1, 0, 0, "R5 forward no hint -> untaken");
    look(A, 1, 1, 0, "R5 backward no hint -> taken");
    look(A, 1, 0, 1, "R5 forward hint -> taken");
    look(A, 1, 1, 1, "R5 backward hint -> untaken");
    look(B, 1, 1, 0, "R5 backward on untaken entry -> taken");
    look(B, 1, 0, 0, "R5 forward on untaken entry -> untaken");

    // R6: updates during static lookups still train the table
    step(1, B, 1, 0, 0, 1, B, 1, "R6 static lookup while training");
    step(1, B, 1, 1, 1, 1, B, 1, "R6 static lookup while training");
    idle(1);
    look(B, 0, 0, 0, "R6 warm dynamic after static training");

    // R2: aliasing through bits outside [9:2]
    upd(32'h0000_0104, 1, "R2 train alias");
    upd(32'hABC0_0106, 1, "R2 train alias high/low bits");
    idle(1);
    look(32'h1234_0507, 0, 0, 0, "R2 alias shares entry -> taken");
    look(32'h0000_0108, 0, 0, 0, "R2 neighbour entry untouched");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra;
      logic [31:0] ua;
      ra = {$urandom} & 32'h0000_003C;
      ua = {$urandom} & 32'h0000_003C;
      step($urandom_range(0, 3) != 0, ra, $urandom_range(0, 3) == 0,
           1'($urandom), 1'($urandom),
           $urandom_range(0, 1) == 1, ua, 1'($urandom), "R3/R5 mixed traffic");
    end
    idle(2);

    // R1: reset mid-run clears trained entries
    do_reset(2);
    look(A, 0, 0, 0, "R1 A untaken after second reset");
    look(32'h1234_0507, 0, 0, 0, "R1 alias entry untaken after reset");
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule